// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a 16-bit CPU bus and the controller of an on-chip flash array. It accepts command writes only at even addresses inside the user ROM window. It decodes one-cycle commands and two-cycle commands, and each two-cycle command finishes with a confirming second write. From these commands it selects what a bus read returns: array contents, the status byte, or the lock state of one block. For program, erase and lock-bit operations it sends one-cycle strobes to the flash back end, with the address, the block index and the data. It also holds the two error bits of the status byte.

Erasing every unlocked block is handled in this block. It steps through the main blocks in ascending order, skips any block whose lock bit is set, and never touches the protected block at the top of the window. For each block it issues a single erase strobe and then waits until the back end is no longer busy. The back end must raise its busy input in the cycle that follows any strobe it receives, and hold it until the operation is complete.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, bus reads return array data and the status byte reads 0x0080: ready, with both error bits clear.
- R2: A write is ignored, and the command state does not advance, if it goes to an odd address, falls outside the ROM window, arrives while the block is busy, or carries an unknown command byte in the first cycle.
- R3: Bits 15..8 of a command write are ignored.
- R4: Low byte FFh selects array reads and low byte 70h selects status reads. Each mode lasts until another command is accepted. The status word is zero except for bit 7 (ready), bit 5 (erase or sequence error) and bit 4 (program error).
- R5: Program is 40h followed by a data write to the same even address. One cycle after the data write is accepted, prog_stb is high for a single cycle with that address and data. If the address differs, no strobe is sent, bit 4 is set and the mode returns to array reads.
- R6: Block erase is 20h followed by D0h. One cycle after the confirm, erase_stb pulses with op_blk = (address - ROM_BASE) >> BLK_SHIFT, and this includes the protected top block.
- R7: 77h then D0h pulses lock_stb with the block index. 71h then D0h makes reads return bit 6 = 1 for an unlocked block and 0 for a locked one, with all other bits 0, until the next command.
- R8: If the second write of a 20h, 77h, 71h or A7h sequence does not have D0h in its low byte, no strobe is sent, bits 5 and 4 are both set, and the mode returns to array reads.
- R9: 50h clears bits 5 and 4, and err_flags along with them, within one cycle. The read mode does not change. err_flags always equals {bit 5, bit 4}.
- R10: While the back end is busy, a strobe is out, or an erase-all is running, reads return the status word with bit 7 = 0. After a program, erase or lock operation, the mode is status reads.
- R11: A7h then D0h sends one erase strobe for each unlocked block from 0 to NMAIN-1 in ascending order. It skips locked blocks and never strobes block NMAIN. Each strobe waits until busy from the previous one has dropped.
- R12: At most one strobe is high in any cycle, and no strobe is high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe |
| bus_re | input | 1 | Bus read strobe |
| bus_addr | input | AW | Bus byte address |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Read data, muxed by mode (0 when not reading) |
| array_rdata | input | 16 | Array word at bus_addr from the back end |
| blk_locked | input | NMAIN+1 | Lock bit of each block, 1 = locked |
| be_busy | input | 1 | Back end operation in progress |
| prog_stb | output | 1 | Program request, one cycle |
| erase_stb | output | 1 | Block erase request, one cycle |
| lock_stb | output | 1 | Lock-bit program request, one cycle |
| op_addr | output | AW | Program address |
| op_blk | output | $clog2(NMAIN+1) | Block index for erase and lock |
| op_data | output | 16 | Program data |
| err_flags | output | 2 | Copy of {erase error, program error} |

## Verification
Read data is combinational from the registered mode, so the bench samples a read one time step after it drives the address, within the same low clock phase. A strobe becomes visible one edge after its confirming write, and a bench-side monitor records it at the next rising edge, together with a cycle stamp. Busy therefore begins two edges after the confirm. Reads issued right after a command expect ready to be 0, and reads issued after a fixed idle wait longer than the stub's busy time expect ready to be 1. For erase-all, the bench checks the gap between logged strobes against the stub's busy length.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int unsigned DW = 16;

    localparam logic [7:0] OP_ARRAY   = 8'hFF;
    localparam logic [7:0] OP_STATUS  = 8'h70;
    localparam logic [7:0] OP_CLEAR   = 8'h50;
    localparam logic [7:0] OP_PROG    = 8'h40;
    localparam logic [7:0] OP_ERASE   = 8'h20;
    localparam logic [7:0] OP_EALL    = 8'hA7;
    localparam logic [7:0] OP_LOCK    = 8'h77;
    localparam logic [7:0] OP_RLOCK   = 8'h71;
    localparam logic [7:0] OP_CONFIRM = 8'hD0;

    typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_LOCK} rd_mode_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_PROG, SQ_ERASE, SQ_EALL, SQ_LOCK, SQ_RLOCK
    } seq_e;

    typedef enum logic [3:0] {
        C_NONE, C_ARRAY, C_STATUS, C_CLEAR, C_PROG,
        C_ERASE, C_EALL, C_LOCK, C_RLOCK
    } cmd_e;

    typedef enum logic [1:0] {EA_IDLE, EA_SCAN, EA_FIRE, EA_WAIT} ea_e;

    typedef struct packed {
        logic ready;
        logic erase_err;
        logic prog_err;
    } sr_t;

    typedef struct packed {
        logic prog;
        logic erase;
        logic lock;
    } stb_t;

    function automatic cmd_e decode_cmd(input logic [7:0] code);
        case (code)
            OP_ARRAY:  return C_ARRAY;
            OP_STATUS: return C_STATUS;
            OP_CLEAR:  return C_CLEAR;
            OP_PROG:   return C_PROG;
            OP_ERASE:  return C_ERASE;
            OP_EALL:   return C_EALL;
            OP_LOCK:   return C_LOCK;
            OP_RLOCK:  return C_RLOCK;
            default:   return C_NONE;
        endcase
    endfunction

    function automatic seq_e follow_on(input cmd_e c);
        case (c)
            C_PROG:  return SQ_PROG;
            C_ERASE: return SQ_ERASE;
            C_EALL:  return SQ_EALL;
            C_LOCK:  return SQ_LOCK;
            C_RLOCK: return SQ_RLOCK;
            default: return SQ_IDLE;
        endcase
    endfunction

    function automatic logic [DW-1:0] status_word(input sr_t s);
        return {8'h00, s.ready, 1'b0, s.erase_err, s.prog_err, 4'h0};
    endfunction

endpackage

// File: rtl/fcs_addr_map.sv
module fcs_addr_map #(
    parameter int unsigned AW        = 16,
    parameter logic [AW-1:0] ROM_BASE = 16'h8000,
    parameter int unsigned BLK_SHIFT = 6,
    parameter int unsigned NBLK      = 14,
    parameter int unsigned BW        = 4
) (
    input  logic [AW-1:0] addr,
    output logic          in_rom,
    output logic          even,
    output logic [BW-1:0] blk
);
    localparam int unsigned   SPAN = NBLK << BLK_SHIFT;
    localparam logic [AW:0]   LO   = {1'b0, ROM_BASE};
    localparam logic [AW:0]   HI   = LO + SPAN[AW:0];

    logic [AW-1:0] offset;

    always_comb begin
        offset = addr - ROM_BASE;
        blk    = BW'(offset >> BLK_SHIFT);
        even   = ~addr[0];
        in_rom = ({1'b0, addr} >= LO) && ({1'b0, addr} < HI);
    end
endmodule

// File: rtl/fcs_status.sv
module fcs_status (
    input  logic clk,
    input  logic rst,
    input  logic set_seq,
    input  logic set_prog,
    input  logic clr,
    output logic sr5,
    output logic sr4
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sr5 <= 1'b0;
            sr4 <= 1'b0;
        end else if (set_seq) begin
            sr5 <= 1'b1;
            sr4 <= 1'b1;
        end else if (set_prog) begin
            sr4 <= 1'b1;
        end else if (clr) begin
            sr5 <= 1'b0;
            sr4 <= 1'b0;
        end
    end

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (clr && !set_seq && !set_prog) |=> (!sr5 && !sr4)); // R9
    AST_SEQ_ERR_SETS: assert property (@(posedge clk) disable iff (rst)
        set_seq |=> (sr5 && sr4)); // R8
    AST_PROG_ERR_SETS: assert property (@(posedge clk) disable iff (rst)
        set_prog |=> sr4); // R5
endmodule

// File: rtl/fcs_erase_all.sv
module fcs_erase_all
    import fcs_pkg::*;
#(
    parameter int unsigned NMAIN = 13,
    parameter int unsigned NBLK  = 14,
    parameter int unsigned BW    = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [NBLK-1:0] locked,
    input  logic            be_busy,
    output logic            active,
    output logic            stb,
    output logic [BW-1:0]   blk
);
    localparam logic [BW-1:0] LAST = BW'(NMAIN);

    ea_e           st_q;
    logic [BW-1:0] idx_q;
    logic          stb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= EA_IDLE;
            idx_q <= '0;
            stb_q <= 1'b0;
        end else begin
            stb_q <= 1'b0;
            case (st_q)
                EA_IDLE: if (start) begin
                    idx_q <= '0;
                    st_q  <= EA_SCAN;
                end
                EA_SCAN: begin
                    if (idx_q == LAST) begin
                        st_q <= EA_IDLE;
                    end else if (!locked[idx_q]) begin
                        stb_q <= 1'b1;
                        st_q  <= EA_FIRE;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                EA_FIRE: st_q <= EA_WAIT;
                EA_WAIT: if (!be_busy) begin
                    idx_q <= idx_q + 1'b1;
                    st_q  <= EA_SCAN;
                end
                default: st_q <= EA_IDLE;
            endcase
        end
    end

    assign active = (st_q != EA_IDLE);
    assign stb    = stb_q;
    assign blk    = idx_q;

    AST_EALL_SPARES_TOP: assert property (@(posedge clk) disable iff (rst)
        stb |-> (blk < LAST)); // R11
    AST_EALL_UNLOCKED_ONLY: assert property (@(posedge clk) disable iff (rst)
        stb |-> !locked[blk]); // R11
    AST_EALL_NO_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (st_q == EA_WAIT && be_busy) |=> !stb); // R11
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int unsigned   AW        = 16,
    parameter logic [AW-1:0] ROM_BASE  = 16'h8000,
    parameter int unsigned   BLK_SHIFT = 6,
    parameter int unsigned   NMAIN     = 13,
    localparam int unsigned  NBLK      = NMAIN + 1,
    localparam int unsigned  BW        = $clog2(NBLK)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_we,
    input  logic            bus_re,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [DW-1:0]   array_rdata,
    input  logic [NBLK-1:0] blk_locked,
    input  logic            be_busy,
    output logic            prog_stb,
    output logic            erase_stb,
    output logic            lock_stb,
    output logic [AW-1:0]   op_addr,
    output logic [BW-1:0]   op_blk,
    output logic [DW-1:0]   op_data,
    output logic [1:0]      err_flags
);
    logic          in_rom, even;
    logic [BW-1:0] wblk;

    fcs_addr_map #(
        .AW(AW), .ROM_BASE(ROM_BASE), .BLK_SHIFT(BLK_SHIFT), .NBLK(NBLK), .BW(BW)
    ) u_map (
        .addr(bus_addr), .in_rom(in_rom), .even(even), .blk(wblk)
    );

    seq_e          seq_q;
    rd_mode_e      mode_q;
    logic [AW-1:0] hold_q;
    logic [BW-1:0] lkblk_q;
    stb_t          stb_q;
    logic [AW-1:0] op_addr_q;
    logic [BW-1:0] op_blk_q;
    logic [DW-1:0] op_data_q;

    logic          busy_int, wr_ok, in_idle, in_two, confirm;
    logic          clr_err, seq_err, prog_err, ea_start;
    logic          ea_active, ea_stb;
    logic [BW-1:0] ea_blk;
    logic          sr5, sr4;
    cmd_e          cmd;

    assign cmd      = decode_cmd(bus_wdata[7:0]);
    assign confirm  = (bus_wdata[7:0] == OP_CONFIRM);
    assign busy_int = be_busy | ea_active | stb_q.prog | stb_q.erase | stb_q.lock;
    assign wr_ok    = bus_we & in_rom & even & ~busy_int;
    assign in_idle  = (seq_q == SQ_IDLE);
    assign in_two   = !in_idle && (seq_q != SQ_PROG);
    assign clr_err  = wr_ok & in_idle & (cmd == C_CLEAR);
    assign seq_err  = wr_ok & in_two & ~confirm;
    assign prog_err = wr_ok & (seq_q == SQ_PROG) & (bus_addr != hold_q);
    assign ea_start = wr_ok & (seq_q == SQ_EALL) & confirm;

    fcs_status u_status (
        .clk(clk), .rst(rst), .set_seq(seq_err), .set_prog(prog_err),
        .clr(clr_err), .sr5(sr5), .sr4(sr4)
    );

    fcs_erase_all #(.NMAIN(NMAIN), .NBLK(NBLK), .BW(BW)) u_eall (
        .clk(clk), .rst(rst), .start(ea_start), .locked(blk_locked),
        .be_busy(be_busy), .active(ea_active), .stb(ea_stb), .blk(ea_blk)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q     <= SQ_IDLE;
            mode_q    <= RM_ARRAY;
            hold_q    <= '0;
            lkblk_q   <= '0;
            stb_q     <= '0;
            op_addr_q <= '0;
            op_blk_q  <= '0;
            op_data_q <= '0;
        end else begin
            stb_q <= '0;
            if (wr_ok) begin
                if (in_idle) begin
                    case (cmd)
                        C_ARRAY:  mode_q <= RM_ARRAY;
                        C_STATUS: mode_q <= RM_STATUS;
                        default:  ;
                    endcase
                    seq_q  <= follow_on(cmd);
                    hold_q <= bus_addr;
                end else begin
                    seq_q <= SQ_IDLE;
                    if (seq_q == SQ_PROG) begin
                        if (bus_addr == hold_q) begin
                            stb_q.prog <= 1'b1;
                            op_addr_q  <= bus_addr;
                            op_data_q  <= bus_wdata;
                            mode_q     <= RM_STATUS;
                        end else begin
                            mode_q <= RM_ARRAY;
                        end
                    end else if (!confirm) begin
                        mode_q <= RM_ARRAY;
                    end else begin
                        case (seq_q)
                            SQ_ERASE: begin
                                stb_q.erase <= 1'b1;
                                op_blk_q    <= wblk;
                                mode_q      <= RM_STATUS;
                            end
                            SQ_LOCK: begin
                                stb_q.lock <= 1'b1;
                                op_blk_q   <= wblk;
                                mode_q     <= RM_STATUS;
                            end
                            SQ_RLOCK: begin
                                lkblk_q <= wblk;
                                mode_q  <= RM_LOCK;
                            end
                            SQ_EALL: mode_q <= RM_STATUS;
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    logic [DW-1:0] status_q;

    always_comb begin
        status_q  = status_word(sr_t'{~busy_int, sr5, sr4});
        bus_rdata = '0;
        if (bus_re) begin
            if (busy_int) begin
                bus_rdata = status_q;
            end else begin
                case (mode_q)
                    RM_STATUS: bus_rdata = status_q;
                    RM_LOCK:   bus_rdata[6] = ~blk_locked[lkblk_q];
                    default:   bus_rdata = array_rdata;
                endcase
            end
        end
    end

    assign prog_stb  = stb_q.prog;
    assign erase_stb = stb_q.erase | ea_stb;
    assign lock_stb  = stb_q.lock;
    assign op_addr   = op_addr_q;
    assign op_blk    = ea_stb ? ea_blk : op_blk_q;
    assign op_data   = op_data_q;
    assign err_flags = {sr5, sr4};

    AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({prog_stb, erase_stb, lock_stb})); // R12
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (prog_stb || erase_stb || lock_stb) |=> !(prog_stb || erase_stb || lock_stb)); // R12
    AST_BUSY_NO_STB: assert property (@(posedge clk) disable iff (rst)
        (bus_we && be_busy) |=> (!prog_stb && !lock_stb)); // R2
    AST_PROG_EVEN: assert property (@(posedge clk) disable iff (rst)
        prog_stb |-> !op_addr[0]); // R5
    AST_READY_LOW: assert property (@(posedge clk) disable iff (rst)
        (bus_re && be_busy) |-> !bus_rdata[7]); // R10
endmodule

// File: tb/test_flash_cmd_seq.sv
module test_flash_cmd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam logic [15:0] BASE = 16'h8000;
    localparam int SHIFT = 6;
    localparam int NMAIN = 13;
    localparam int NBLK = NMAIN + 1;
    localparam int BW = 4;
    localparam int BUSY_CYC = 3;
    localparam logic [15:0] PAT = 16'hC3A5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_we = 1'b0, bus_re = 1'b0;
    logic [AW-1:0] bus_addr = BASE;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata, array_rdata, op_data;
    logic [NBLK-1:0] locked = '0;
    logic be_busy;
    logic prog_stb, erase_stb, lock_stb;
    logic [AW-1:0] op_addr;
    logic [BW-1:0] op_blk;
    logic [1:0] err_flags;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_cmd_seq i_flash_cmd_seq (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .array_rdata(array_rdata), .blk_locked(locked), .be_busy(be_busy),
        .prog_stb(prog_stb), .erase_stb(erase_stb), .lock_stb(lock_stb),
        .op_addr(op_addr), .op_blk(op_blk), .op_data(op_data), .err_flags(err_flags)
    );

    // back end stub
    assign array_rdata = bus_addr ^ PAT;
    int busy_cnt = 0;
    assign be_busy = (busy_cnt != 0);
    int cyc = 0;
    int pcnt = 0, ecnt = 0, lcnt = 0;
    logic [15:0] last_paddr, last_pdata;
    logic [3:0]  last_lblk;
    int elog[64];
    int etime[64];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) busy_cnt <= 0;
        else if (prog_stb || erase_stb || lock_stb) busy_cnt <= BUSY_CYC;
        else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
        if (!rst && prog_stb) begin
            pcnt <= pcnt + 1; last_paddr <= op_addr; last_pdata <= op_data;
        end
        if (!rst && erase_stb) begin
            elog[ecnt % 64] <= int'(op_blk); etime[ecnt % 64] <= cyc; ecnt <= ecnt + 1;
        end
        if (!rst && lock_stb) begin
            lcnt <= lcnt + 1; last_lblk <= op_blk; locked[op_blk] <= 1'b1;
        end
    end

    int nchk = 0, nerr = 0;
    bit done = 0;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] baddr(input int b, input int off);
        return BASE + 16'(b << SHIFT) + 16'(off);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        int p0, e0, l0, k;
        int exp_blk[16];
        int nexp;
        logic [7:0] code;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(BASE + 16'h10, r); chk("R1 array after reset", r, (BASE + 16'h10) ^ PAT);
        chk("R1 err_flags", {14'b0, err_flags}, 16'h0);
        wr(BASE, 16'h0070);
        rd(BASE, r); chk("R1 status after reset", r, 16'h0080);

        // R4: array mode persists over a full sweep, status mode persists
        wr(BASE, 16'h00FF);
        for (int a = 0; a < (NBLK << SHIFT); a += 2) begin
            rd(BASE + 16'(a), r);
            chk("R4 array sweep", r, (BASE + 16'(a)) ^ PAT);
        end
        wr(BASE + 16'h20, 16'h0070);
        for (int i = 0; i < 4; i++) begin
            rd(BASE + 16'(i * 6), r); chk("R4 status persists", r, 16'h0080);
        end

        // R3: high byte ignored, swept
        for (int h = 0; h < 256; h++) begin
            wr(BASE + 16'h40, {h[7:0], 8'h70});
            rd(BASE + 16'h4, r); chk("R3 status any high byte", r, 16'h0080);
            wr(BASE + 16'h40, {h[7:0], 8'hFF});
            rd(BASE + 16'h4, r); chk("R3 array any high byte", r, (BASE + 16'h4) ^ PAT);
        end

        // R2: unknown first-cycle codes ignored
        p0 = pcnt; e0 = ecnt; l0 = lcnt;
        for (int c = 0; c < 256; c++) begin
            code = c[7:0];
            if (code == 8'hFF || code == 8'h70 || code == 8'h50 || code == 8'h40 ||
                code == 8'h20 || code == 8'hA7 || code == 8'h77 || code == 8'h71) continue;
            wr(BASE + 16'h8, {8'h00, code});
            rd(BASE + 16'hC, r); chk("R2 unknown code ignored", r, (BASE + 16'hC) ^ PAT);
        end
        chk("R2 no strobes from unknown codes", 16'(pcnt + ecnt + lcnt), 16'(p0 + e0 + l0));
        wr(BASE, 16'h0070);
        rd(BASE, r); chk("R2 idle after unknown codes", r, 16'h0080);

        // R2: odd, below, above window
        wr(BASE, 16'h00FF);
        wr(BASE + 16'h1, 16'h0070);
        rd(BASE, r); chk("R2 odd address ignored", r, BASE ^ PAT);
        wr(BASE - 16'h2, 16'h0070);
        rd(BASE, r); chk("R2 below window ignored", r, BASE ^ PAT);
        wr(BASE + 16'(NBLK << SHIFT), 16'h0070);
        rd(BASE, r); chk("R2 above window ignored", r, BASE ^ PAT);
        wr(BASE + 16'h3, 16'h0040);
        wr(BASE + 16'h2, 16'h0070);
        rd(BASE, r); chk("R2 odd 40h did not start program", r, 16'h0080);
        chk("R2 no program strobe", 16'(pcnt), 16'(p0));

        // R5 and R10: program, busy reads, ignored write during busy
        wr(BASE, 16'h00FF);
        wr(BASE + 16'h52, 16'h0040);
        wr(BASE + 16'h52, 16'hBEEF);
        rd(BASE, r); chk("R10 ready low while busy", r, 16'h0000);
        wr(BASE, 16'h00FF);
        idle(BUSY_CYC + 4);
        chk("R5 one program strobe", 16'(pcnt), 16'(p0 + 1));
        chk("R5 program address", last_paddr, BASE + 16'h52);
        chk("R5 program data", last_pdata, 16'hBEEF);
        rd(BASE, r); chk("R10 status mode after program, R2 busy write ignored", r, 16'h0080);

        // R5: address mismatch
        wr(BASE + 16'h60, 16'h0040);
        wr(BASE + 16'h62, 16'h5555);
        idle(2);
        chk("R5 mismatch no strobe", 16'(pcnt), 16'(p0 + 1));
        rd(BASE + 16'h6, r); chk("R5 mismatch array mode", r, (BASE + 16'h6) ^ PAT);
        chk("R9 err_flags program", {14'b0, err_flags}, 16'h0001);
        wr(BASE, 16'h0070);
        rd(BASE, r); chk("R5 program error bit", r, 16'h0090);

        // R9: clear keeps mode
        wr(BASE, 16'h0050);
        rd(BASE, r); chk("R9 clear keeps status mode", r, 16'h0080);
        chk("R9 err_flags cleared", {14'b0, err_flags}, 16'h0);

        // R8: bad confirm for every two-cycle command
        foreach (exp_blk[i]) exp_blk[i] = 0;
        for (int j = 0; j < 4; j++) begin
            code = (j == 0) ? 8'h20 : (j == 1) ? 8'h77 : (j == 2) ? 8'h71 : 8'hA7;
            p0 = pcnt; e0 = ecnt; l0 = lcnt;
            wr(BASE, 16'h0070);
            wr(BASE + 16'h80, {8'h00, code});
            wr(BASE + 16'hBE, 16'hD0FF);
            idle(2);
            chk("R8 no strobe on bad confirm", 16'(pcnt + ecnt + lcnt), 16'(p0 + e0 + l0));
            rd(BASE + 16'hA, r); chk("R8 array mode after bad confirm", r, (BASE + 16'hA) ^ PAT);
            chk("R8 both error flags", {14'b0, err_flags}, 16'h0003);
            wr(BASE, 16'h0070);
            rd(BASE, r); chk("R8 status shows sequence error", r, 16'h00B0);
            wr(BASE, 16'h0050);
        end

        // R6: block erase of every block including the top one
        for (int b = 0; b < NBLK; b++) begin
            e0 = ecnt;
            wr(baddr(b, 0), 16'hAA20);
            wr(baddr(b, (1 << SHIFT) - 2), 16'h00D0);
            idle(BUSY_CYC + 4);
            chk("R6 one erase strobe", 16'(ecnt), 16'(e0 + 1));
            chk("R6 erase block index", 16'(elog[e0 % 64]), 16'(b));
            rd(BASE, r); chk("R10 status after erase", r, 16'h0080);
        end

        // R7: lock blocks 3, 7 and the top block, then read all lock states
        for (int j = 0; j < 3; j++) begin
            k = (j == 0) ? 3 : (j == 1) ? 7 : NMAIN;
            l0 = lcnt;
            wr(baddr(k, 4), 16'h0077);
            wr(baddr(k, (1 << SHIFT) - 2), 16'h00D0);
            idle(BUSY_CYC + 4);
            chk("R7 one lock strobe", 16'(lcnt), 16'(l0 + 1));
            chk("R7 lock block index", {12'b0, last_lblk}, 16'(k));
        end
        for (int b = 0; b < NBLK; b++) begin
            wr(baddr(b, 0), 16'h0071);
            wr(baddr(b, (1 << SHIFT) - 2), 16'h00D0);
            rd(BASE, r);
            chk("R7 lock status read",
                r, (b == 3 || b == 7 || b == NMAIN) ? 16'h0000 : 16'h0040);
            rd(BASE + 16'h2, r);
            chk("R7 lock mode persists",
                r, (b == 3 || b == 7 || b == NMAIN) ? 16'h0000 : 16'h0040);
        end

        // R11: erase all unlocked
        nexp = 0;
        for (int b = 0; b < NMAIN; b++)
            if (b != 3 && b != 7) begin exp_blk[nexp] = b; nexp++; end
        e0 = ecnt;
        wr(BASE + 16'h10, 16'h00A7);
        wr(BASE + 16'h24, 16'h00D0);
        rd(BASE, r); chk("R10 ready low during erase-all", r, 16'h0000);
        wr(BASE, 16'h00FF);
        idle(200);
        chk("R11 erase-all strobe count", 16'(ecnt - e0), 16'(nexp));
        for (int i = 0; i < nexp; i++)
            chk("R11 erase-all order", 16'(elog[(e0 + i) % 64]), 16'(exp_blk[i]));
        for (int i = 1; i < nexp; i++)
            chk("R11 erase-all waits for busy",
                16'((etime[(e0 + i) % 64] - etime[(e0 + i - 1) % 64]) > BUSY_CYC), 16'h1);
        rd(BASE, r); chk("R11 status after erase-all, busy write ignored", r, 16'h0080);

        // R12: strobes were single pulses (counts equal operations)
        chk("R12 total lock strobes", 16'(lcnt), 16'h3);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule